// File: doc/BRIEF.md
# Byte-Granular Instruction Buffer

This block sits between an instruction cache and the decoder of a processor whose instructions are a one-byte opcode followed by a variable number of operand bytes. The cache side delivers fixed 4-byte words. The decode side always sees a window of the 5 oldest bytes and reports back how many of them it used, from 0 to 5. The buffer holds 12 bytes in a circular store. A head pointer moves by whatever byte count the decoder consumed, so the window is realigned at byte granularity.

A write and a consume may happen in the same cycle, and both take effect. Write-ready is computed after subtracting the bytes consumed in that cycle, so a buffer that is full at the start of a cycle can still take a word when the decoder frees enough room. A redirect asserts flush, which empties the buffer in one cycle and drops any write offered in that cycle.

Top module: `instr_byte_buffer`

## Requirements
- R1: After reset the valid-byte count is 0 and write-ready is 1.
- R2: Window byte i (rd_data bits 8i+7..8i) is the i-th oldest unconsumed byte, with byte 0 the oldest. This holds across wrap-around of the circular store.
- R3: The valid-byte count equals the smaller of the occupancy and 5.
- R4: A written word enters in fetch order: wr_data bits 7..0 are the first (oldest) byte and bits 31..24 the last.
- R5: Write-ready is 1 exactly when occupancy minus this cycle's effective consume count is at most 8, so that 4 bytes are free.
- R6: A write offered while write-ready is 0 is ignored: no byte is added.
- R7: A consume count larger than the valid-byte count removes only the valid bytes.
- R8: A write and a consume in the same cycle are both applied. Occupancy changes by 4 minus the consumed count.
- R9: Flush empties the buffer in one cycle. It discards a write and a consume offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Empty the buffer (redirect) |
| wr_valid | input | 1 | A 4-byte word is offered |
| wr_data | input | 32 | Offered word, bits 7..0 first in fetch order |
| wr_ready | output | 1 | Word is accepted this cycle if wr_valid |
| cons_cnt | input | 3 | Bytes the decoder takes from the window this cycle |
| rd_valid_cnt | output | 3 | Number of real bytes in the window |
| rd_data | output | 40 | Window, bits 7..0 are the oldest byte |

## Verification
The bench builds the block with its default parameters: 12 bytes of storage, a 4-byte write and a 5-byte window. At this size a few thousand cycles of mixed stimulus cover every occupancy from 0 to 12. That stimulus combines every consume value from 0 to 7, writes that are accepted or refused, and flushes. The head and tail pointers wrap around the non-power-of-two store many times. A byte-queue model in the bench predicts write-ready before each edge and the window contents after it.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  localparam int unsigned BYTE_BITS = 8;
  typedef logic [BYTE_BITS-1:0] ibyte_t;
endpackage

// File: rtl/ibuf_rst_sync.sv
module ibuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage1     <= 1'b1;
      rst_n_sync <= stage1;
    end
  end
endmodule

// File: rtl/ibuf_occupancy.sv
module ibuf_occupancy #(
  parameter int DEPTH    = 12,
  parameter int WR_BYTES = 4,
  parameter int RD_BYTES = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CON_W = $clog2(RD_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_valid,
  input  logic [CON_W-1:0] cons_cnt,
  output logic             wr_ready,
  output logic             wr_accept,
  output logic [CON_W-1:0] valid_cnt,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail
);
  localparam int SUM_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] RD_C    = CNT_W'(RD_BYTES);
  localparam logic [CNT_W-1:0] WR_C    = CNT_W'(WR_BYTES);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(DEPTH - WR_BYTES);
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);
  localparam logic [SUM_W-1:0] WR_S    = SUM_W'(WR_BYTES);

  logic [CNT_W-1:0] count, count_n;
  logic [PTR_W-1:0] head_n, tail_n;
  logic [CNT_W-1:0] vis, cons_c, eff, remain;
  logic [SUM_W-1:0] hsum, tsum;
  logic             upd_en;

  // window occupancy, clamp of the consume count, room check
  always_comb begin
    vis       = (count > RD_C) ? RD_C : count;
    cons_c    = CNT_W'(cons_cnt);
    eff       = (cons_c > vis) ? vis : cons_c;
    remain    = count - eff;
    wr_ready  = (remain <= LIMIT_C);
    wr_accept = wr_valid && wr_ready && !flush;
    valid_cnt = CON_W'(vis);
  end

  // next pointers with wrap over a non-power-of-two store
  always_comb begin
    hsum = SUM_W'(head) + SUM_W'(eff);
    tsum = SUM_W'(tail) + (wr_accept ? WR_S : '0);
    if (flush) begin
      count_n = '0;
      head_n  = '0;
      tail_n  = '0;
    end else begin
      count_n = remain + (wr_accept ? WR_C : '0);
      head_n  = (hsum >= DEPTH_S) ? PTR_W'(hsum - DEPTH_S) : PTR_W'(hsum);
      tail_n  = (tsum >= DEPTH_S) ? PTR_W'(tsum - DEPTH_S) : PTR_W'(tsum);
    end
    upd_en = flush || wr_accept || (eff != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      head  <= '0;
      tail  <= '0;
    end else if (upd_en) begin
      count <= count_n;
      head  <= head_n;
      tail  <= tail_n;
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  assert_blocked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !flush) |=> (count <= $past(count)));

  assert_valid_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(valid_cnt) <= RD_C) && (CNT_W'(valid_cnt) <= count));

  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_c > vis && count <= RD_C && !wr_accept && !flush) |=> (count == '0));
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store #(
  parameter int DEPTH    = 12,
  parameter int WR_BYTES = 4,
  parameter int BYTE_W   = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           tail,
  input  logic [WR_BYTES*BYTE_W-1:0] wr_data,
  output logic [DEPTH*BYTE_W-1:0]    mem_flat
);
  localparam int SUM_W = PTR_W + 1;
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);
  localparam logic [SUM_W-1:0] WR_S    = SUM_W'(WR_BYTES);

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [SUM_W-1:0]  off;
    logic              hit;
    logic [BYTE_W-1:0] byte_in;
    logic [BYTE_W-1:0] slot_q;

    always_comb begin
      if (SUM_W'(j) >= SUM_W'(tail)) off = SUM_W'(j) - SUM_W'(tail);
      else                           off = SUM_W'(j) + DEPTH_S - SUM_W'(tail);
      hit     = wr_en && (off < WR_S);
      byte_in = '0;
      for (int k = 0; k < WR_BYTES; k++) begin
        if (off == SUM_W'(k)) byte_in = wr_data[k*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (hit) slot_q <= byte_in;
    end

    assign mem_flat[j*BYTE_W +: BYTE_W] = slot_q;
  end
endmodule

// File: rtl/ibuf_window.sv
module ibuf_window #(
  parameter int DEPTH    = 12,
  parameter int RD_BYTES = 5,
  parameter int BYTE_W   = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH*BYTE_W-1:0]    mem_flat,
  input  logic [PTR_W-1:0]           head,
  output logic [RD_BYTES*BYTE_W-1:0] rd_data
);
  localparam int SUM_W = PTR_W + 1;
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);

  for (genvar i = 0; i < RD_BYTES; i++) begin : g_lane
    logic [SUM_W-1:0]  pos;
    logic [BYTE_W-1:0] lane;

    always_comb begin
      pos = SUM_W'(head) + SUM_W'(i);
      if (pos >= DEPTH_S) pos = pos - DEPTH_S;
      lane = '0;
      for (int s = 0; s < DEPTH; s++) begin
        if (pos == SUM_W'(s)) lane = mem_flat[s*BYTE_W +: BYTE_W];
      end
    end

    assign rd_data[i*BYTE_W +: BYTE_W] = lane;
  end
endmodule

// File: rtl/instr_byte_buffer.sv
module instr_byte_buffer #(
  parameter int DEPTH    = 12,
  parameter int WR_BYTES = 4,
  parameter int RD_BYTES = 5,
  localparam int BYTE_W = ibuf_pkg::BYTE_BITS,
  localparam int CON_W  = $clog2(RD_BYTES + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_valid,
  input  logic [WR_BYTES*BYTE_W-1:0] wr_data,
  output logic                       wr_ready,
  input  logic [CON_W-1:0]           cons_cnt,
  output logic [CON_W-1:0]           rd_valid_cnt,
  output logic [RD_BYTES*BYTE_W-1:0] rd_data
);
  logic                    rst_n_sync;
  logic                    wr_accept;
  logic [PTR_W-1:0]        head, tail;
  logic [DEPTH*BYTE_W-1:0] mem_flat;

  ibuf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ibuf_occupancy #(.DEPTH(DEPTH), .WR_BYTES(WR_BYTES), .RD_BYTES(RD_BYTES)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .flush     (flush),
    .wr_valid  (wr_valid),
    .cons_cnt  (cons_cnt),
    .wr_ready  (wr_ready),
    .wr_accept (wr_accept),
    .valid_cnt (rd_valid_cnt),
    .head      (head),
    .tail      (tail)
  );

  ibuf_store #(.DEPTH(DEPTH), .WR_BYTES(WR_BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk      (clk),
    .wr_en    (wr_accept),
    .tail     (tail),
    .wr_data  (wr_data),
    .mem_flat (mem_flat)
  );

  ibuf_window #(.DEPTH(DEPTH), .RD_BYTES(RD_BYTES), .BYTE_W(BYTE_W)) u_win (
    .mem_flat (mem_flat),
    .head     (head),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/tb_instr_byte_buffer.sv
module tb_instr_byte_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic        wr_ready;
  logic [2:0]  cons_cnt;
  logic [2:0]  rd_valid_cnt;
  logic [39:0] rd_data;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done   = 1'b0;
  logic [7:0]  mq[$];
  logic [7:0]  seq_b  = 8'h10;
  logic [15:0] lfsr   = 16'hACE1;

  always #2 clk = ~clk;

  instr_byte_buffer dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .cons_cnt(cons_cnt),
    .rd_valid_cnt(rd_valid_cnt), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_window(input string tag);
    int vis;
    vis = (mq.size() > 5) ? 5 : int'(mq.size());
    chk({tag, " valid count (R3)"}, 64'(rd_valid_cnt), 64'(vis));
    for (int i = 0; i < vis; i++)
      chk({tag, " window byte (R2)"}, 64'(rd_data[i*8 +: 8]), 64'(mq[i]));
  endtask

  // one cycle: drive at negedge, check ready, model at posedge, check after
  task automatic step(input bit wv, input bit fl, input int cons);
    int    vis, eff;
    bit    exp_rdy, acc;
    string tag;
    wr_valid = wv;
    flush    = fl;
    cons_cnt = 3'(cons);
    wr_data  = {seq_b + 8'd3, seq_b + 8'd2, seq_b + 8'd1, seq_b};
    #1;
    vis     = (mq.size() > 5) ? 5 : int'(mq.size());
    eff     = (cons > vis) ? vis : cons;
    exp_rdy = ((int'(mq.size()) - eff) <= 8);
    chk("R5 write-ready", 64'(wr_ready), 64'(exp_rdy));
    acc = wv && exp_rdy && !fl;
    if (fl)                 tag = "R9 flush";
    else if (wv && !exp_rdy) tag = "R6 refused write";
    else if (cons > vis)    tag = "R7 clamp";
    else if (acc && eff > 0) tag = "R8 write+consume";
    else if (acc)           tag = "R4 write order";
    else                    tag = "R2 window";
    @(posedge clk);
    if (fl) mq.delete();
    else begin
      for (int i = 0; i < eff; i++) void'(mq.pop_front());
      if (acc) begin
        for (int i = 0; i < 4; i++) mq.push_back(seq_b + 8'(i));
        seq_b = seq_b + 8'd4;
      end
    end
    @(negedge clk);
    check_window(tag);
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    rst_n = 1'b0; flush = 1'b0; wr_valid = 1'b0; wr_data = '0; cons_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid count", 64'(rd_valid_cnt), 64'd0);
    chk("R1 reset write-ready", 64'(wr_ready), 64'd1);
    // fill to capacity, then a refused write with no consume
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    // consume 3 while writing when full: 12-3=9 > 8, refused
    step(1'b1, 1'b0, 3);
    // consume 4 while writing: 9-4... occupancy 9, minus 4 = 5, accepted
    step(1'b1, 1'b0, 4);
    // flush with write and consume offered
    step(1'b1, 1'b1, 5);
    // small occupancy with over-consume
    step(1'b1, 1'b0, 0);
    step(1'b0, 1'b0, 7);
    step(1'b1, 1'b0, 0);
    step(1'b0, 1'b0, 2);
    step(1'b0, 1'b0, 6);
    // sweep of every consume value against many occupancy levels
    for (int r = 0; r < 3000; r++) begin
      lfsr = nxt(lfsr);
      step(lfsr[3] | lfsr[9], (r % 211) == 105, int'(lfsr[2:0]));
    end
    // drain completely and check empty window
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule